// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside an asynchronous SRAM-style port and listens to its read traffic for a hidden unlock pattern. Each chip-enable falling edge is presented to the block as a one-clock access strobe, together with the address bus and the level of the active-low write enable at that moment. When five fixed read addresses arrive in the right order, and a sixth read names one of four command codes, the block raises exactly one of its four command outputs for a single clock.

The four commands are: save to non-volatile storage, restore from non-volatile storage, turn automatic saving off, and turn automatic saving on. Any write access, or any read that does not fit the next step, aborts a run in progress. A read of the first pattern address always begins a fresh run, even when it interrupts another run. Only the low 14 address bits are compared.

Top module: `seq_cmd_detect`

## Requirements
- R1: An asynchronous active-low reset clears the run progress to zero and holds all four command outputs low.
- R2: Only cycles with the access strobe high are sampled. Cycles without the strobe change nothing, whatever the address and write-enable levels are, so idle cycles between the accesses of a run do not break it.
- R3: A strobed read is an access with `writeEnN` high. The read addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in exactly that order, followed by a sixth read of a command code, raise the matching command output in the clock cycle after the sixth strobe.
- R4: The sixth-step codes map as follows: 0x0FC0 to `cmdSave`, 0x0C63 to `cmdRestore`, 0x03F8 to `cmdAutoOff`, 0x07F0 to `cmdAutoOn`.
- R5: Address bit 14 takes no part in any comparison. Only bits 13..0 are compared.
- R6: A strobed access with `writeEnN` low aborts the run. Progress returns to zero, even if the address is 0x0E38.
- R7: A strobed read that does not match the expected step aborts the run and yields no command. If the address of that read is 0x0E38, it counts as step one of a new run; otherwise progress returns to zero.
- R8: A sixth read that matches none of the four codes raises no output and restarts matching under the rule of R7.
- R9: At most one command output is high in any cycle, and each pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accStrobe | input | 1 | One-clock marker of a chip-enable falling edge |
| writeEnN | input | 1 | Write enable level at the access, active low (high means read) |
| addr | input | 15 | Access address |
| cmdSave | output | 1 | Save command pulse |
| cmdRestore | output | 1 | Restore command pulse |
| cmdAutoOff | output | 1 | Automatic-save disable pulse |
| cmdAutoOn | output | 1 | Automatic-save enable pulse |

## Verification
The bench plays runs that are broken by a write at the first pattern address and by a repeated first address in the middle of a run. A detector that treats the write as a read, or that drops the restarted run, would fire on the wrong run or miss the pulse. It also sets the ignored top address bit on every access and inserts idle cycles carrying noise addresses. A design that compares 15 bits, or samples without the strobe, would stay silent where a pulse is expected. Unknown sixth codes, each of the four valid codes, and the cycle after each pulse are checked, which catches swapped outputs, pulses that last two cycles, and commands issued on a bad final step.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;
  localparam int CMP_W   = 14;
  localparam int STEP_W  = 3;
  localparam int N_PRE   = 5;
  localparam int N_CMD   = 4;

  localparam logic [CMP_W-1:0] PRE_CODE [N_PRE] = '{
    14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F
  };

  // index order: save, restore, auto off, auto on
  localparam logic [CMP_W-1:0] CMD_CODE [N_CMD] = '{
    14'h0FC0, 14'h0C63, 14'h03F8, 14'h07F0
  };

  typedef struct packed {
    logic             sample;
    logic             isRead;
    logic [STEP_W-1:0] step;
  } seqView_t;

  typedef struct packed {
    logic             stepHit;
    logic             firstHit;
    logic [N_CMD-1:0] cmdHit;
  } matchInfo_t;

  typedef struct packed {
    logic             fire;
    logic [N_CMD-1:0] cmdSel;
  } fireCtrl_t;
endpackage

// File: rtl/seq_cmd_path.sv
module seq_cmd_path
  import seq_cmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  seqView_t          view,
  input  fireCtrl_t         fireCtl,
  output matchInfo_t        match,
  output logic [N_CMD-1:0]  cmdOut
);
  logic [CMP_W-1:0] lowAddr;
  logic [CMP_W-1:0] expected;
  logic [N_CMD-1:0] cmdHitVec;

  assign lowAddr = addr[CMP_W-1:0];

  always_comb begin
    expected = PRE_CODE[0];
    for (int i = 0; i < N_PRE; i++) begin
      if (view.step == STEP_W'(i)) expected = PRE_CODE[i];
    end
  end

  for (genvar c = 0; c < N_CMD; c++) begin : g_cmd
    assign cmdHitVec[c] = (lowAddr == CMD_CODE[c]);
  end

  assign match.stepHit  = (view.step < STEP_W'(N_PRE)) && (lowAddr == expected);
  assign match.firstHit = (lowAddr == PRE_CODE[0]);
  assign match.cmdHit   = (view.step == STEP_W'(N_PRE)) ? cmdHitVec : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmdOut <= '0;
    else if (fireCtl.fire) cmdOut <= fireCtl.cmdSel;
    else                   cmdOut <= '0;
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdOut));

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|cmdOut) |=> !(|cmdOut));
endmodule

// File: rtl/seq_cmd_ctrl.sv
module seq_cmd_ctrl
  import seq_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accStrobe,
  input  logic       writeEnN,
  input  matchInfo_t match,
  output seqView_t   view,
  output fireCtrl_t  fireCtl
);
  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] stepD;
  logic              restartStep;

  assign view.sample = accStrobe;
  assign view.isRead = writeEnN;
  assign view.step   = stepQ;

  assign restartStep = match.firstHit;

  always_comb begin
    stepD          = stepQ;
    fireCtl.fire   = 1'b0;
    fireCtl.cmdSel = '0;
    if (accStrobe) begin
      if (!writeEnN) begin
        stepD = '0;
      end else if (stepQ == STEP_W'(N_PRE)) begin
        if (|match.cmdHit) begin
          fireCtl.fire   = 1'b1;
          fireCtl.cmdSel = match.cmdHit;
          stepD          = '0;
        end else begin
          stepD = restartStep ? STEP_W'(1) : '0;
        end
      end else if (match.stepHit) begin
        stepD = stepQ + STEP_W'(1);
      end else begin
        stepD = restartStep ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepQ <= '0;
    else       stepQ <= stepD;
  end

  p_step_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepQ <= STEP_W'(N_PRE));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !accStrobe |=> $stable(stepQ));

  p_write_abort_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && !writeEnN) |=> (stepQ == '0));
endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
  import seq_cmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStrobe,
  input  logic              writeEnN,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmdSave,
  output logic              cmdRestore,
  output logic              cmdAutoOff,
  output logic              cmdAutoOn
);
  seqView_t         view;
  matchInfo_t       match;
  fireCtrl_t        fireCtl;
  logic [N_CMD-1:0] cmdOut;

  seq_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accStrobe (accStrobe),
    .writeEnN  (writeEnN),
    .match     (match),
    .view      (view),
    .fireCtl   (fireCtl)
  );

  seq_cmd_path #(.ADDR_W(ADDR_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .view    (view),
    .fireCtl (fireCtl),
    .match   (match),
    .cmdOut  (cmdOut)
  );

  assign cmdSave    = cmdOut[0];
  assign cmdRestore = cmdOut[1];
  assign cmdAutoOff = cmdOut[2];
  assign cmdAutoOn  = cmdOut[3];
endmodule

// File: tb/seq_cmd_detect_test.sv
module seq_cmd_detect_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accStrobe = 1'b0;
  logic        writeEnN = 1'b1;
  logic [14:0] addr = '0;
  logic        cmdSave, cmdRestore, cmdAutoOff, cmdAutoOn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [14:0] seqA [0:7];
  logic        seqW [0:7];

  seq_cmd_detect uut (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .writeEnN(writeEnN),
    .addr(addr), .cmdSave(cmdSave), .cmdRestore(cmdRestore),
    .cmdAutoOff(cmdAutoOff), .cmdAutoOn(cmdAutoOn)
  );

  always #2.5 clk = ~clk;

  function automatic logic [3:0] outs();
    return {cmdAutoOn, cmdAutoOff, cmdRestore, cmdSave};
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accStrobe = 1'b0;
      addr      = 15'(16'h0E38 ^ (i * 16'h1357));
      writeEnN  = i[0];
    end
  endtask

  task automatic access(input logic [14:0] a, input logic w, output logic [3:0] seen);
    @(negedge clk);
    accStrobe = 1'b1;
    addr      = a;
    writeEnN  = w;
    @(negedge clk);
    seen      = outs();
    accStrobe = 1'b0;
    writeEnN  = 1'b1;
  endtask

  // Plays n accesses from seqA/seqW, optional idle gap, expects exp after the last
  task automatic play(input int n, input int gap, input logic [3:0] exp, input string req);
    logic [3:0] seen;
    logic [3:0] early = '0;
    for (int i = 0; i < n; i++) begin
      access(seqA[i], seqW[i], seen);
      if (i < n - 1) begin
        early |= seen;
        if (gap > 0) idle(gap);
      end
    end
    check(early, 4'b0000, {req, " no early pulse"});
    check(seen, exp, req);
    @(negedge clk);
    check(outs(), 4'b0000, "R9 pulse ends after one cycle");
  endtask

  task automatic loadPrefix(input logic [14:0] last);
    seqA[0] = 15'h0E38; seqA[1] = 15'h31C7; seqA[2] = 15'h03E0;
    seqA[3] = 15'h3C1F; seqA[4] = 15'h303F; seqA[5] = last;
    for (int i = 0; i < 8; i++) seqW[i] = 1'b1;
  endtask

  task automatic testReset();
    check(outs(), 4'b0000, "R1 outputs low in reset");
    @(negedge clk); rstN = 1'b1;
    check(outs(), 4'b0000, "R1 outputs low after reset");
  endtask

  task automatic testCodes();
    loadPrefix(15'h0FC0); play(6, 0, 4'b0001, "R3 R4 save");
    loadPrefix(15'h0C63); play(6, 0, 4'b0010, "R4 restore");
    loadPrefix(15'h03F8); play(6, 0, 4'b0100, "R4 auto off");
    loadPrefix(15'h07F0); play(6, 0, 4'b1000, "R4 auto on");
  endtask

  task automatic testIdleGaps();
    loadPrefix(15'h0C63); play(6, 3, 4'b0010, "R2 idle gaps keep run");
  endtask

  task automatic testTopBit();
    loadPrefix(15'h07F0);
    for (int i = 0; i < 6; i++) seqA[i][14] = 1'b1;
    play(6, 0, 4'b1000, "R5 top bit ignored");
  endtask

  task automatic testWriteAbort();
    // write at 0x0E38 mid-run must not restart a run: remaining five give nothing
    loadPrefix(15'h0FC0);
    seqA[0] = 15'h0E38; seqA[1] = 15'h31C7; seqA[2] = 15'h0E38; seqW[2] = 1'b0;
    seqA[3] = 15'h31C7; seqA[4] = 15'h03E0; seqA[5] = 15'h3C1F;
    seqA[6] = 15'h303F; seqA[7] = 15'h0FC0;
    play(8, 0, 4'b0000, "R6 write aborts run");
    loadPrefix(15'h03F8); seqW[3] = 1'b0;
    play(6, 0, 4'b0000, "R6 write inside prefix");
  endtask

  task automatic testRestart();
    loadPrefix(15'h0FC0);
    seqA[0] = 15'h0E38; seqA[1] = 15'h31C7; seqA[2] = 15'h0E38;
    seqA[3] = 15'h31C7; seqA[4] = 15'h03E0; seqA[5] = 15'h3C1F;
    seqA[6] = 15'h303F; seqA[7] = 15'h0FC0;
    play(8, 0, 4'b0001, "R7 0x0E38 restarts run");
    loadPrefix(15'h0C63); seqA[2] = 15'h3C1F;
    play(6, 0, 4'b0000, "R7 out of order aborts");
    loadPrefix(15'h0C63); seqA[1] = 15'h1234;
    play(6, 0, 4'b0000, "R7 foreign address aborts");
  endtask

  task automatic testBadFinal();
    loadPrefix(15'h0FC1); play(6, 0, 4'b0000, "R8 unknown final code");
    // unknown final 0x0E38 restarts: five more reads complete a run
    loadPrefix(15'h0E38);
    seqA[6] = 15'h31C7; seqA[7] = 15'h03E0;
    play(8, 0, 4'b0000, "R8 final 0x0E38 partial");
    loadPrefix(15'h03F8);
    seqA[0] = 15'h3C1F; seqA[1] = 15'h303F; seqA[2] = 15'h07F0;
    play(3, 0, 4'b1000, "R8 R7 run after final restart");
  endtask

  initial begin
    testReset();
    testCodes();
    testIdleGaps();
    testTopBit();
    testWriteAbort();
    testRestart();
    testBadFinal();
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule